// File: doc/BRIEF.md
# Serial controller interrupt identification unit

This block is the interrupt front end of a serial port controller. It holds a four-bit interrupt enable register and takes raw event flags from the rest of the controller: a receive line error, receive data ready, a receive character timeout, an empty transmit holding register, and a modem status change. It masks the events with the enable bits and picks the single most urgent one. It reports that event in an eight-bit identification byte and drives an active-high interrupt line.

The line error, data ready, timeout and modem flags are levels that the logic that owns them clears upstream. The transmit-holding-empty condition is the exception, and the block tracks it itself with a two-state machine. In state `TX_QUIET` no holding-empty interrupt is pending. The ARM transition moves to `TX_PENDING` when the holding register becomes empty, or when its enable bit is written from 0 to 1 while the register is empty. The CLEAR transition returns to `TX_QUIET` on a write to the holding register, or on a read of the identification byte while holding-empty is the source it reports. If both transitions apply in the same cycle, CLEAR wins.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register reads back as written in bits 3:0, and bits 7:4 always read as zero. Bit 0 enables data ready and timeout, bit 1 enables holding-empty, bit 2 enables line error, and bit 3 enables modem status.
- R2: Identification bit 0 reads 0 while an enabled interrupt is pending and 1 otherwise. `irq` is high exactly when bit 0 is 0.
- R3: The reported source follows a fixed priority, from highest to lowest: line error, then data ready, then timeout, then holding-empty, then modem status. Data ready and timeout share the second level, and within that level data ready is reported first.
- R4: Identification bits 3:0 read 0110 for line error, 0100 for data ready, 1100 for timeout, 0010 for holding-empty, 0000 for modem status and 0001 when nothing is pending.
- R5: The timeout event is considered only when `fifo_en` is 1. When `fifo_en` is 0, identification bit 3 is always 0.
- R6: Identification bits 5:4 always read as zero. Bits 7:6 both equal `fifo_en`.
- R7: With the enable register at zero, no event raises `irq`.
- R8: A read of the identification byte clears a pending holding-empty interrupt only when holding-empty is the source reported in that cycle. A read that reports another source leaves it pending.
- R9: A write to the transmit holding register clears a pending holding-empty interrupt.
- R10: A pending holding-empty interrupt is armed by a 0-to-1 change of `thr_empty`, or by writing enable bit 1 from 0 to 1 while `thr_empty` is 1.
- R11: After reset the enable register is zero, the identification byte reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Read strobe for the identification byte |
| iir_o | output | 8 | Identification byte |
| thr_wr | input | 1 | Write strobe of the transmit holding register |
| fifo_en | input | 1 | FIFO mode enable |
| ev_line_err | input | 1 | Receive line error flag |
| ev_rx_ready | input | 1 | Receive data ready flag |
| ev_char_tmo | input | 1 | Receive character timeout flag |
| thr_empty | input | 1 | Transmit holding register empty |
| ev_modem | input | 1 | Modem status change flag |
| irq | output | 1 | Interrupt output, active high |

## Verification
An exhaustive sweep covers both FIFO modes, all sixteen enable patterns and all thirty-two combinations of the four level events and a pending holding-empty state. The sweep tells a correct priority order apart from a swapped one, and it tells mask decoding apart from a wrong bit assignment. It also shows whether timeout is ignored outside FIFO mode. Directed sequences then drive the holding-empty state machine through each ARM and CLEAR path. Among them is an identification read that takes place while a higher-priority source hides holding-empty, which separates a conditional clear from an unconditional one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        SRC_LINE    = 3'd0,
        SRC_RXDATA  = 3'd1,
        SRC_TIMEOUT = 3'd2,
        SRC_THRE    = 3'd3,
        SRC_MODEM   = 3'd4,
        SRC_NONE    = 3'd5
    } irq_src_t;

    typedef enum logic {
        TX_QUIET   = 1'b0,
        TX_PENDING = 1'b1
    } thre_state_t;

    localparam logic [3:0] NIB_LINE    = 4'b0110;
    localparam logic [3:0] NIB_RXDATA  = 4'b0100;
    localparam logic [3:0] NIB_TIMEOUT = 4'b1100;
    localparam logic [3:0] NIB_THRE    = 4'b0010;
    localparam logic [3:0] NIB_MODEM   = 4'b0000;
    localparam logic [3:0] NIB_NONE    = 4'b0001;

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
    parameter int DATA_W  = 8,
    parameter int EN_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [EN_BITS-1:0] en,
    output logic [DATA_W-1:0]  rdata,
    output logic               thre_en_rise
);
    localparam int PAD_W = DATA_W - EN_BITS;

    logic [EN_BITS-1:0] en_q;
    logic               unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:EN_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr)
            en_q <= wdata[EN_BITS-1:0];
    end

    assign en           = en_q;
    assign rdata        = {{PAD_W{1'b0}}, en_q};
    assign thre_en_rise = wr && wdata[1] && !en_q[1];

    // R1: the register takes the written low bits on the next edge
    p_ier_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> rdata[EN_BITS-1:0] == $past(wdata[EN_BITS-1:0]));

    // R1: without a write the register holds
    p_ier_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(rdata));

endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic iir_rd,
    input  logic reported,
    input  logic en_rise,
    output logic pending
);
    thre_state_t state_q, state_d;
    logic        empty_q;
    logic        arm, clr;

    assign arm = (thr_empty && !empty_q) || (en_rise && thr_empty);
    assign clr = thr_wr || (iir_rd && reported);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_QUIET;
            empty_q <= 1'b1;
        end else begin
            state_q <= state_d;
            empty_q <= thr_empty;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET:   if (arm && !clr) state_d = TX_PENDING;
            TX_PENDING: if (clr)         state_d = TX_QUIET;
            default:    state_d = TX_QUIET;
        endcase
    end

    always_comb begin
        pending = (state_q == TX_PENDING);
    end

    // R9: a holding register write always ends the pending state
    p_thr_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !pending);

    // R8: a read that reports holding-empty clears it
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && reported) |=> !pending);

    // R10: an empty rise with no clear arms the interrupt
    p_empty_rise_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && !empty_q && !clr) |=> pending);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int EN_BITS = 4
) (
    input  logic [EN_BITS-1:0] en,
    input  logic               fifo_en,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               char_tmo,
    input  logic               thre_pend,
    input  logic               modem,
    output irq_src_t           src
);
    logic act_line, act_rx, act_tmo, act_thre, act_modem;

    always_comb begin
        act_line  = en[2] && line_err;
        act_rx    = en[0] && rx_ready;
        act_tmo   = en[0] && char_tmo && fifo_en;
        act_thre  = en[1] && thre_pend;
        act_modem = en[3] && modem;
    end

    always_comb begin
        if (act_line)       src = SRC_LINE;
        else if (act_rx)    src = SRC_RXDATA;
        else if (act_tmo)   src = SRC_TIMEOUT;
        else if (act_thre)  src = SRC_THRE;
        else if (act_modem) src = SRC_MODEM;
        else                src = SRC_NONE;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int EN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_wdata,
    output logic [DATA_W-1:0] ier_rdata,
    input  logic              iir_rd,
    output logic [7:0]        iir_o,
    input  logic              thr_wr,
    input  logic              fifo_en,
    input  logic              ev_line_err,
    input  logic              ev_rx_ready,
    input  logic              ev_char_tmo,
    input  logic              thr_empty,
    input  logic              ev_modem,
    output logic              irq
);
    logic [EN_BITS-1:0] en;
    logic               thre_en_rise;
    logic               thre_pend;
    irq_src_t           src;
    logic [3:0]         nib;

    uart_irq_enable_reg #(.DATA_W(DATA_W), .EN_BITS(EN_BITS)) u_ier (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (ier_wr),
        .wdata        (ier_wdata),
        .en           (en),
        .rdata        (ier_rdata),
        .thre_en_rise (thre_en_rise)
    );

    uart_irq_thre_fsm u_thre (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .thr_wr    (thr_wr),
        .iir_rd    (iir_rd),
        .reported  (src == SRC_THRE),
        .en_rise   (thre_en_rise),
        .pending   (thre_pend)
    );

    uart_irq_prio #(.EN_BITS(EN_BITS)) u_prio (
        .en        (en),
        .fifo_en   (fifo_en),
        .line_err  (ev_line_err),
        .rx_ready  (ev_rx_ready),
        .char_tmo  (ev_char_tmo),
        .thre_pend (thre_pend),
        .modem     (ev_modem),
        .src       (src)
    );

    always_comb begin
        unique case (src)
            SRC_LINE:    nib = NIB_LINE;
            SRC_RXDATA:  nib = NIB_RXDATA;
            SRC_TIMEOUT: nib = NIB_TIMEOUT;
            SRC_THRE:    nib = NIB_THRE;
            SRC_MODEM:   nib = NIB_MODEM;
            default:     nib = NIB_NONE;
        endcase
    end

    always_comb begin
        iir_o = {fifo_en, fifo_en, 2'b00, nib};
        irq   = (src != SRC_NONE);
    end

    // R2: the output line and the active-low pending bit agree
    p_irq_vs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_o[0]);

    // R7: a cleared enable register keeps the line low
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata == '0) |-> !irq);

    // R3: an enabled line error is always the reported source
    p_line_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[2] && ev_line_err) |-> (iir_o[3:0] == 4'b0110));

    // R5: no timeout flag outside FIFO mode
    p_no_tmo_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !iir_o[3]);

    // R6: the unused pair stays zero
    p_mid_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[5:4] == 2'b00);

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [7:0] ier_rdata;
    logic       iir_rd = 1'b0;
    logic [7:0] iir_o;
    logic       thr_wr = 1'b0;
    logic       fifo_en = 1'b0;
    logic       ev_line_err = 1'b0;
    logic       ev_rx_ready = 1'b0;
    logic       ev_char_tmo = 1'b0;
    logic       thr_empty = 1'b1;
    logic       ev_modem = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    uart_irq_ident u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_wr      (ier_wr),
        .ier_wdata   (ier_wdata),
        .ier_rdata   (ier_rdata),
        .iir_rd      (iir_rd),
        .iir_o       (iir_o),
        .thr_wr      (thr_wr),
        .fifo_en     (fifo_en),
        .ev_line_err (ev_line_err),
        .ev_rx_ready (ev_rx_ready),
        .ev_char_tmo (ev_char_tmo),
        .thr_empty   (thr_empty),
        .ev_modem    (ev_modem),
        .irq         (irq)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [7:0] model(input logic f, input logic [3:0] en,
                                         input logic le, input logic rx,
                                         input logic tm, input logic th,
                                         input logic ms);
        logic [3:0] n;
        if (en[2] && le)            n = 4'h6;
        else if (en[0] && rx)       n = 4'h4;
        else if (en[0] && tm && f)  n = 4'hC;
        else if (en[1] && th)       n = 4'h2;
        else if (en[3] && ms)       n = 4'h0;
        else                        n = 4'h1;
        return {f, f, 2'b00, n};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] e;
        step();
        step();
        // R11: reset state
        check8(ier_rdata, 8'h00, "R11 ier");
        check8(iir_o, 8'h01, "R11 iir");
        check8({7'd0, irq}, 8'h00, "R11 irq");
        rst_n = 1'b1;
        step();

        // R1: readback and upper bits
        ier_wr = 1'b1; ier_wdata = 8'hF8; step();
        ier_wr = 1'b0; check8(ier_rdata, 8'h08, "R1 F8");
        ier_wr = 1'b1; ier_wdata = 8'h00; step();
        ier_wr = 1'b0; check8(ier_rdata, 8'h00, "R1 clear");

        // R10: enable rise with empty register arms holding-empty
        ier_wr = 1'b1; ier_wdata = 8'h02; step();
        ier_wr = 1'b0; step();
        check8(iir_o, 8'h02, "R10 enable rise");
        check8({7'd0, irq}, 8'h01, "R2 irq");
        // R8: read while reported clears it
        iir_rd = 1'b1; step();
        iir_rd = 1'b0; check8(iir_o, 8'h01, "R8 read clears");
        // R10: empty rise arms
        thr_empty = 1'b0; step();
        thr_empty = 1'b1; step();
        check8(iir_o, 8'h02, "R10 empty rise");
        // R8: read hidden by line error leaves it
        ier_wr = 1'b1; ier_wdata = 8'h06; step();
        ier_wr = 1'b0; ev_line_err = 1'b1; step();
        check8(iir_o, 8'h06, "R3 line over thre");
        iir_rd = 1'b1; step();
        iir_rd = 1'b0; ev_line_err = 1'b0; step();
        check8(iir_o, 8'h02, "R8 hidden read keeps");
        // R9: holding write clears
        thr_wr = 1'b1; step();
        thr_wr = 1'b0; check8(iir_o, 8'h01, "R9 write clears");
        // R10: enable toggle re-arms
        ier_wr = 1'b1; ier_wdata = 8'h00; step();
        ier_wdata = 8'h02; step();
        ier_wr = 1'b0; check8(iir_o, 8'h02, "R10 toggle");

        // Sweep: R2 R3 R4 R5 R6 R7
        for (int f = 0; f < 2; f++) begin
            for (int en = 0; en < 16; en++) begin
                for (int ev = 0; ev < 32; ev++) begin
                    thr_empty = 1'b0; thr_wr = 1'b1;
                    ev_line_err = 0; ev_rx_ready = 0; ev_char_tmo = 0; ev_modem = 0;
                    step();
                    thr_wr = 1'b0; ier_wr = 1'b1; ier_wdata = 8'(en);
                    step();
                    ier_wr = 1'b0;
                    fifo_en     = f[0];
                    ev_line_err = ev[0];
                    ev_rx_ready = ev[1];
                    ev_char_tmo = ev[2];
                    thr_empty   = ev[3];
                    ev_modem    = ev[4];
                    step();
                    e = model(f[0], 4'(en), ev[0], ev[1], ev[2], ev[3], ev[4]);
                    check8(iir_o, e, "R2 R3 R4 R5 R6 R7 iir");
                    check8({7'd0, irq}, {7'd0, ~e[0]}, "R2 R7 irq");
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule